// File: doc/BRIEF.md
# Fail-Safe Image Update Controller

This block steers a field update of a configuration image into a serial flash that holds two image slots. It keeps track of which slot holds the image the device is running. Every incoming image byte goes to the other slot, at consecutive byte addresses. While the bytes are accepted and written, it folds each one into a 16-bit CRC. When the transfer ends, it compares that CRC against the CRC supplied with the image.

Only a matching CRC produces a one-cycle reconfiguration request toward the internal configuration port. After that request the block records the freshly written slot as the running one. A mismatch, an image too large for its slot, or an abort leaves the running slot untouched and the request low. The device therefore always has a bootable image, even with no supervisor watching.

Top module: `img_update_ctrl`

## Requirements
- R1: After reset the controller is idle: reconfig_req_o, done_o and error_o are low, and active_slot_o equals boot_slot_i.
- R2: Slot 0 starts at byte address 0 and slot 1 at byte address SLOT_BYTES (0x080000 by default). Every write lands in the slot whose index differs from active_slot_o.
- R3: Byte k of an image (counting from 0) is written to the target slot base plus k. flash_we_o is high only in a cycle where s_valid_i and s_ready_o are both high, and flash_wdata_o equals s_data_i in that cycle.
- R4: While flash_ready_i is low, s_ready_o and flash_we_o stay low and no byte is consumed.
- R5: The CRC uses polynomial 0x8005 with initial value 0x0000, processes each byte most significant bit first, and covers every accepted byte including the one marked by s_last_i. For the ASCII string "123456789" the CRC is 0xFEE8.
- R6: If the CRC equals exp_crc_i, reconfig_req_o and done_o go high for exactly one cycle, two cycles after the clock edge that accepts the last byte.
- R7: Each reconfiguration request flips active_slot_o, so the next image is written to the slot that was just used as the running slot before the flip.
- R8: If the CRC does not equal exp_crc_i, error_o goes high for one cycle at the same point where a request would have fired. reconfig_req_o stays low and active_slot_o is unchanged.
- R9: A byte offered after SLOT_BYTES bytes have been written is not accepted and not written. error_o pulses on the next cycle and no request follows.
- R10: abort_i, during a transfer or during the CRC compare, returns the controller to idle. No request or error is raised, active_slot_o is unchanged, and the next image restarts at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_slot_i | input | 1 | Slot the device booted from, loaded at reset |
| abort_i | input | 1 | Cancel the update in progress |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Controller accepts the byte |
| exp_crc_i | input | 16 | Expected CRC of the image |
| flash_addr_o | output | 24 | Flash byte address |
| flash_wdata_o | output | 8 | Flash write byte |
| flash_we_o | output | 1 | Flash write strobe |
| flash_ready_i | input | 1 | Flash can take a write |
| reconfig_req_o | output | 1 | One-cycle reconfiguration request |
| done_o | output | 1 | Update finished with a good image |
| error_o | output | 1 | Update rejected |
| active_slot_o | output | 1 | Slot holding the running image |

## Verification
The hardest case to reach from the ports is slot overflow, because it takes a whole slot's worth of bytes without a last marker. The bench therefore builds the controller with a 16-byte slot. It sweeps every image length from 1 to 16, alternating good and corrupted CRCs and inserting flash stalls, and then offers a seventeenth byte to force the overflow. Aborts are injected both in the middle of a stream and in the single compare cycle, which the bench locates by counting edges from the last accepted byte.

// File: rtl/img_upd_pkg.sv
package img_upd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_CHECK,
    ST_TRIGGER,
    ST_FAIL
  } upd_state_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int          CRC_W = 16,
  parameter int          DAT_W = 8,
  parameter logic [15:0] POLY  = 16'h8005
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DAT_W-1:0] data_i,
  output logic [CRC_W-1:0] crc_o
);
  always_comb begin
    logic [CRC_W-1:0] c;
    c = crc_i;
    for (int i = DAT_W - 1; i >= 0; i--) begin
      if (c[CRC_W-1] ^ data_i[i]) c = {c[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
      else                        c = {c[CRC_W-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_slot_i,
  input  logic flip_i,
  output logic active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= boot_slot_i;
    else if (flip_i) active_o <= ~active_o;
  end
endmodule

// File: rtl/img_update_ctrl.sv
module img_update_ctrl
  import img_upd_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          DAT_W      = 8,
  parameter int          CRC_W      = 16,
  parameter int          SLOT_BYTES = 32'h0008_0000,
  parameter logic [15:0] CRC_POLY   = 16'h8005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_slot_i,
  input  logic              abort_i,
  input  logic [DAT_W-1:0]  s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic [CRC_W-1:0]  exp_crc_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DAT_W-1:0]  flash_wdata_o,
  output logic              flash_we_o,
  input  logic              flash_ready_i,
  output logic              reconfig_req_o,
  output logic              done_o,
  output logic              error_o,
  output logic              active_slot_o
);
  localparam int               CNT_W    = $clog2(SLOT_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOT_BYTES);
  localparam logic [ADDR_W-1:0] BASE1   = ADDR_W'(SLOT_BYTES);

  upd_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_base;
  logic [CRC_W-1:0]  crc_q, crc_base, crc_nxt;
  logic [ADDR_W-1:0] tgt_base;
  logic              accepting, full, fire;

  // a fresh image restarts offset and CRC from the idle state
  assign cnt_base  = (state_q == ST_IDLE) ? '0 : cnt_q;
  assign crc_base  = (state_q == ST_IDLE) ? '0 : crc_q;
  assign accepting = (state_q == ST_IDLE) || (state_q == ST_WRITE);
  assign full      = (cnt_base == CNT_FULL);
  assign s_ready_o = accepting && flash_ready_i && !abort_i && !full;
  assign fire      = s_valid_i && s_ready_o;

  assign tgt_base      = active_slot_o ? '0 : BASE1;
  assign flash_addr_o  = tgt_base + ADDR_W'(cnt_base);
  assign flash_wdata_o = s_data_i;
  assign flash_we_o    = fire;

  assign reconfig_req_o = (state_q == ST_TRIGGER);
  assign done_o         = (state_q == ST_TRIGGER);
  assign error_o        = (state_q == ST_FAIL);

  crc_byte_step #(.CRC_W(CRC_W), .DAT_W(DAT_W), .POLY(CRC_POLY)) i_crc (
    .crc_i  (crc_base),
    .data_i (s_data_i),
    .crc_o  (crc_nxt)
  );

  slot_tracker i_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_slot_i (boot_slot_i),
    .flip_i      (reconfig_req_o),
    .active_o    (active_slot_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fire) state_d = s_last_i ? ST_CHECK : ST_WRITE;
      ST_WRITE: begin
        if (abort_i)                  state_d = ST_IDLE;
        else if (fire && s_last_i)    state_d = ST_CHECK;
        else if (s_valid_i && full)   state_d = ST_FAIL;
      end
      ST_CHECK: begin
        if (abort_i)                  state_d = ST_IDLE;
        else if (crc_q == exp_crc_i)  state_d = ST_TRIGGER;
        else                          state_d = ST_FAIL;
      end
      ST_TRIGGER: state_d = ST_IDLE;
      ST_FAIL:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      crc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fire) begin
        cnt_q <= cnt_base + 1'b1;
        crc_q <= crc_nxt;
      end
    end
  end

  // R2
  write_in_spare_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> (active_slot_o ? (flash_addr_o < BASE1)
                                  : (flash_addr_o >= BASE1 && flash_addr_o - BASE1 < BASE1)));
  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_we_o && !s_last_i) |=> (flash_addr_o == $past(flash_addr_o) + 1'b1));
  // R4
  stall_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_ready_i |-> !flash_we_o);
  // R6
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconfig_req_o |=> !reconfig_req_o);
  // R7
  slot_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconfig_req_o |=> (active_slot_o != $past(active_slot_o)));
  // R8
  err_keeps_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> (active_slot_o == $past(active_slot_o)));
  // R10
  abort_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !reconfig_req_o) |=> !reconfig_req_o);
endmodule

// File: tb/test_img_update_ctrl.sv
module test_img_update_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 16;

  logic        clk = 0, rst_n = 0;
  logic        boot_slot = 1, abort = 0;
  logic [7:0]  data = 0;
  logic        valid = 0, last = 0, fready = 1;
  logic [15:0] exp_crc = 0;
  logic        s_ready, we, req, done, err, active;
  logic [23:0] addr;
  logic [7:0]  wdata;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  img_update_ctrl #(.SLOT_BYTES(SLOT)) i_img_update_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .boot_slot_i(boot_slot), .abort_i(abort),
    .s_data_i(data), .s_valid_i(valid), .s_last_i(last), .s_ready_o(s_ready),
    .exp_crc_i(exp_crc), .flash_addr_o(addr), .flash_wdata_o(wdata),
    .flash_we_o(we), .flash_ready_i(fready), .reconfig_req_o(req),
    .done_o(done), .error_o(err), .active_slot_o(active));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 91 + 5) ^ (i << 3));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // drive bytes 0..len-1; checks on each write; returns the ref CRC
  task automatic stream(input int seed, input int len, input bit mark_last,
                        input bit stall, output logic [15:0] crc);
    logic [23:0] base = active ? 24'd0 : 24'(SLOT);
    crc = 16'h0;
    for (int i = 0; i < len; i++) begin
      data = pat(seed, i); valid = 1; last = mark_last && (i == len - 1);
      if (stall && (i % 3 == 1)) begin
        fready = 0; #1;
        chk(!s_ready && !we, "R4 stall", {s_ready, we}, 0);
        @(posedge clk); @(negedge clk);
        fready = 1;
      end
      #1;
      chk(we && s_ready, "R3 strobe", we, 1);
      chk(addr == base + 24'(i), "R2/R3 addr", addr, base + 24'(i));
      chk(wdata == data, "R3 wdata", wdata, data);
      crc = ref_crc(crc, data);
      @(posedge clk); @(negedge clk);
    end
    valid = 0; last = 0;
  endtask

  task automatic full_image(input int seed, input int len, input bit good, input bit stall);
    logic [15:0] c;
    logic a0 = active;
    stream(seed, len, 1, stall, c);
    exp_crc = good ? c : c ^ 16'h0101;
    #1; chk(!req && !err, "R6 compare cycle quiet", req, 0);
    @(negedge clk); #1;
    if (good) begin
      chk(req && done && !err, "R6 request", {req, done, err}, 3'b110);
    end else begin
      chk(err && !req && !done, "R8 error", {req, done, err}, 3'b001);
    end
    @(negedge clk); #1;
    chk(!req && !done && !err, "R6 single pulse", {req, done, err}, 0);
    chk(active == (good ? !a0 : a0), good ? "R7 flip" : "R8 slot kept", active, good ? !a0 : a0);
  endtask

  initial begin
    logic [15:0] c;
    logic a0;
    // R5: known string check against the reference
    c = 16'h0;
    for (int i = 0; i < 9; i++) c = ref_crc(c, 8'h31 + 8'(i));
    chk(c == 16'hFEE8, "R5 check value", c, 16'hFEE8);

    #(CLK_PERIOD * 2);
    @(negedge clk); rst_n = 1; #1;
    chk(!req && !done && !err && active == 1'b1, "R1 reset", {req, done, err, active}, 1);

    // R5 R6 R8: every length, alternating verdicts and stalls
    for (int len = 1; len <= SLOT; len++) begin
      full_image(len, len, len % 2 == 0, len % 4 < 2);
      @(negedge clk);
    end
    // R5: the known string through the design
    c = 16'h0;
    for (int i = 0; i < 9; i++) begin
      data = 8'h31 + 8'(i); valid = 1; last = (i == 8);
      c = ref_crc(c, data);
      @(posedge clk); @(negedge clk);
    end
    valid = 0; last = 0; exp_crc = 16'hFEE8; a0 = active;
    @(negedge clk); #1;
    chk(req, "R5 string crc", req, 1);
    @(negedge clk);
    chk(active != a0, "R7 flip after string", active, !a0);

    // R9: overflow
    a0 = active;
    stream(77, SLOT, 0, 0, c);
    data = 8'hAA; valid = 1; #1;
    chk(!s_ready && !we, "R9 extra byte refused", {s_ready, we}, 0);
    @(negedge clk); valid = 0; #1;
    chk(err && !req, "R9 error", {err, req}, 2'b10);
    @(negedge clk); #1;
    chk(active == a0 && !req, "R9 slot kept", active, a0);

    // R10: abort mid-stream
    stream(5, 3, 0, 0, c);
    abort = 1; #1;
    chk(!s_ready, "R10 abort blocks", s_ready, 0);
    @(negedge clk); abort = 0;
    @(negedge clk); #1;
    chk(!req && !err && active == a0, "R10 abort quiet", {req, err}, 0);
    full_image(9, 4, 1, 0);   // restarts at offset 0 (R10)

    // R10: abort in compare cycle with a correct CRC
    a0 = active;
    stream(11, 5, 1, 0, c);
    exp_crc = c; abort = 1;
    @(negedge clk); abort = 0; #1;
    chk(!req && !err, "R10 abort at compare", {req, err}, 0);
    @(negedge clk); #1;
    chk(!req && active == a0, "R10 slot kept", active, a0);
    full_image(12, 2, 1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule